// File: doc/BRIEF.md
# TDM Parallel/Serial Stream Converter

The block converts between a byte-wide time-division bus and a bank of serial TDM streams. A frame lasts 2048 cycles of the 16.384 MHz master clock and carries 1024 channels. The same counter, lane registers and slot decoder serve both directions and both serial rates. A static direction input selects the conversion. A static rate input chooses between 32 streams with 8-clock bit cells and 16 streams with 4-clock bit cells. Both direction and rate are set while reset is asserted.

On the parallel side a new byte slot begins every two clocks. Within each channel period, slot k belongs to stream k. Each stream lane holds two registers: one collects the next channel and the other shifts the current one. The serial side therefore runs without a gap, and every byte crosses the block with a latency of exactly one channel period. Serial drivers and the parallel driver are modelled as data and enable pairs. In parallel-to-serial mode a per-byte disable flag switches off one stream's driver for that stream's whole timeslot.

Top module: `tdm_par_ser_conv`

## Requirements
- R1: With mode_i=1 (parallel to serial), p_oe_o stays 0. With mode_i=0 (serial to parallel), every bit of ser_oe_o stays 0.
- R2: If fp_i is sampled high at a clock edge, the next cycle is frame cycle 0. Otherwise the frame cycle counts up and wraps from 2047 to 0. The MSB of a channel's first byte appears on the serial stream in frame cycle 0.
- R3: With rate_i=0, 32 streams are used, a bit cell lasts 8 clocks and a channel period lasts 64 clocks. With rate_i=1, 16 streams are used, a bit cell lasts 4 clocks and a channel period lasts 32 clocks. In that mode streams 16 to 31 are never enabled and their ser_i is ignored.
- R4: Byte slot k covers cycles 2k and 2k+1 of a channel period and belongs to stream k. p_i and tri_i are captured at the edge that ends cycle 2k+1. This holds for the last slot of a period too, whose byte goes straight into the next period's shift.
- R5: Serial bits are sent and received MSB first. Bit 7 occupies the first bit cell of a channel period, and bit 0 occupies the last.
- R6: In parallel-to-serial mode, the bytes captured during channel period c are shifted out on their streams during period c+1, with no idle cell between channels.
- R7: In parallel-to-serial mode, if tri_i=1 is captured with a byte, that stream's ser_oe_o is 0 for the whole period in which that byte would be sent.
- R8: In serial-to-parallel mode, each ser_i bit is sampled at the last clock of its bit cell. The byte received on stream k in period c is presented on p_o, with p_oe_o=1, in slot k of period c+1.
- R9: During reset, and in the first channel period after reset, all drivers are off: ser_oe_o=0 and p_oe_o=0.
- R10: After fp_i is sampled high in the middle of a channel period, timing restarts at frame cycle 0. From the second channel period after the pulse, the output is exact again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 16.384 MHz master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 1: parallel to serial, 0: serial to parallel |
| rate_i | input | 1 | 0: 32 streams, 8-clock bits; 1: 16 streams, 4-clock bits |
| fp_i | input | 1 | Frame pulse, next cycle is frame cycle 0 |
| p_i | input | 8 | Parallel byte in |
| tri_i | input | 1 | Disable the serial driver for the byte in this slot |
| ser_i | input | 32 | Serial stream inputs |
| p_o | output | 8 | Parallel byte out |
| p_oe_o | output | 1 | Parallel driver enable |
| ser_o | output | 32 | Serial stream outputs |
| ser_oe_o | output | 32 | Per-stream serial driver enable |

## Verification
The reference model tracks channel periods by their count since reset. It expects each period to carry the bytes of the previous one. A design that loses the bypass into the shift register for the last slot would corrupt the final stream of every channel. A design that shifts LSB first, or uses the wrong cell length for the rate, fails on the first bit cell. A design that keeps an old disable flag would get the driver enables wrong for the affected timeslots. The checks also cover the driver-off state of the first period after reset, a mid-period frame pulse followed by re-alignment, and random data on the unused upper streams in the 16-stream mode, where a design that decodes them would put false bytes on the bus.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int BYTE_W       = 8;
  localparam int MAX_STREAMS  = 32;
  localparam int FRAME_CYC    = 2048;
  localparam int BIT_CYC_SLOW = 8;
  localparam int BYTE_CYC     = 2;

  typedef enum logic {DIR_S2P = 1'b0, DIR_P2S = 1'b1} dir_e;
  typedef enum logic {RATE_SLOW = 1'b0, RATE_FAST = 1'b1} rate_e;
endpackage

// File: rtl/tdm_timebase.sv
module tdm_timebase #(
  parameter int FRAME_CYC    = tdm_pkg::FRAME_CYC,
  parameter int BIT_CYC_SLOW = tdm_pkg::BIT_CYC_SLOW,
  parameter int BYTE_W       = tdm_pkg::BYTE_W,
  parameter int BYTE_CYC     = tdm_pkg::BYTE_CYC,
  parameter int STREAMS      = tdm_pkg::MAX_STREAMS,
  localparam int SW  = $clog2(STREAMS),
  localparam int BSW = $clog2(BYTE_W)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           fp_i,
  input  logic           fast_i,
  output logic [SW-1:0]  slot_o,
  output logic [BSW-1:0] bitsel_o,
  output logic           cap_o,
  output logic           bit_end_o,
  output logic           chan_end_o
);
  localparam int CNT_W = $clog2(FRAME_CYC);
  localparam int BL_S  = $clog2(BIT_CYC_SLOW);
  localparam int BL_F  = BL_S - 1;
  localparam int CH_S  = BL_S + BSW;
  localparam int CH_F  = CH_S - 1;
  localparam int BY_L  = $clog2(BYTE_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt <= '0;
    else if (fp_i)                          cnt <= '0;
    else if (cnt == CNT_W'(FRAME_CYC - 1))  cnt <= '0;
    else                                    cnt <= cnt + 1'b1;
  end

  always_comb begin
    cap_o = &cnt[BY_L-1:0];
    if (fast_i) begin
      slot_o     = SW'(cnt[CH_F-1:BY_L]);
      bitsel_o   = cnt[CH_F-1:BL_F];
      bit_end_o  = &cnt[BL_F-1:0];
      chan_end_o = &cnt[CH_F-1:0];
    end else begin
      slot_o     = SW'(cnt[CH_S-1:BY_L]);
      bitsel_o   = cnt[CH_S-1:BL_S];
      bit_end_o  = &cnt[BL_S-1:0];
      chan_end_o = &cnt[CH_S-1:0];
    end
  end

  p_fp_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_i |=> (cnt == '0));
  p_frame_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fp_i && cnt == CNT_W'(FRAME_CYC - 1)) |=> (cnt == '0));
endmodule

// File: rtl/tdm_lane.sv
module tdm_lane #(
  parameter int BYTE_W = tdm_pkg::BYTE_W,
  localparam int BSW = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              p2s_i,
  input  logic              active_i,
  input  logic              cap_i,
  input  logic              chan_end_i,
  input  logic              bit_end_i,
  input  logic [BSW-1:0]    bitsel_i,
  input  logic [BYTE_W-1:0] p_i,
  input  logic              tri_i,
  input  logic              ser_i,
  output logic              ser_o,
  output logic              ser_oe_o,
  output logic [BYTE_W-1:0] hold_o,
  output logic              hold_vld_o
);
  logic [BYTE_W-1:0] hold, sh;
  logic              hold_dis, sh_en, hv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold <= '0; sh <= '0; hold_dis <= 1'b0; sh_en <= 1'b0; hv <= 1'b0;
    end else if (p2s_i) begin
      if (cap_i) begin
        hold     <= p_i;
        hold_dis <= tri_i;
      end
      if (chan_end_i) begin
        // last slot of the period bypasses the hold register
        sh    <= cap_i ? p_i : hold;
        sh_en <= active_i & ~(cap_i ? tri_i : hold_dis);
      end
    end else begin
      if (bit_end_i) sh <= {sh[BYTE_W-2:0], ser_i};
      if (chan_end_i) begin
        hold <= {sh[BYTE_W-2:0], ser_i};
        hv   <= active_i;
      end
    end
  end

  assign ser_oe_o   = p2s_i & sh_en;
  assign ser_o      = ser_oe_o & sh[BSW'(BYTE_W-1) - bitsel_i];
  assign hold_o     = hold;
  assign hold_vld_o = ~p2s_i & hv;

  p_idle_lane_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p2s_i && chan_end_i && !active_i) |=> !ser_oe_o);
  p_tri_slot_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p2s_i && chan_end_i && !cap_i && hold_dis) |=> !ser_oe_o);
  p_rx_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!p2s_i && chan_end_i && active_i) |=> hold_vld_o);
endmodule

// File: rtl/tdm_par_ser_conv.sv
module tdm_par_ser_conv #(
  parameter int BYTE_W       = tdm_pkg::BYTE_W,
  parameter int STREAMS      = tdm_pkg::MAX_STREAMS,
  parameter int FRAME_CYC    = tdm_pkg::FRAME_CYC,
  parameter int BIT_CYC_SLOW = tdm_pkg::BIT_CYC_SLOW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_i,
  input  logic               rate_i,
  input  logic               fp_i,
  input  logic [BYTE_W-1:0]  p_i,
  input  logic               tri_i,
  input  logic [STREAMS-1:0] ser_i,
  output logic [BYTE_W-1:0]  p_o,
  output logic               p_oe_o,
  output logic [STREAMS-1:0] ser_o,
  output logic [STREAMS-1:0] ser_oe_o
);
  import tdm_pkg::*;
  localparam int SW  = $clog2(STREAMS);
  localparam int BSW = $clog2(BYTE_W);

  dir_e           dir;
  rate_e          rate;
  logic [SW-1:0]  slot;
  logic [BSW-1:0] bitsel;
  logic           cap, bit_end, chan_end;
  logic [BYTE_W-1:0] hold_all [STREAMS];
  logic [STREAMS-1:0] hold_vld;

  assign dir  = dir_e'(mode_i);
  assign rate = rate_e'(rate_i);

  tdm_timebase #(
    .FRAME_CYC(FRAME_CYC), .BIT_CYC_SLOW(BIT_CYC_SLOW), .BYTE_W(BYTE_W),
    .BYTE_CYC(BYTE_CYC), .STREAMS(STREAMS)
  ) i_timebase (
    .clk_i, .rst_ni, .fp_i,
    .fast_i(rate == RATE_FAST),
    .slot_o(slot), .bitsel_o(bitsel), .cap_o(cap),
    .bit_end_o(bit_end), .chan_end_o(chan_end)
  );

  for (genvar i = 0; i < STREAMS; i++) begin : g_lane
    localparam bit UPPER = (i >= STREAMS / 2);
    tdm_lane #(.BYTE_W(BYTE_W)) i_lane (
      .clk_i, .rst_ni,
      .p2s_i(dir == DIR_P2S),
      .active_i(!(UPPER && rate == RATE_FAST)),
      .cap_i(cap && slot == SW'(i)),
      .chan_end_i(chan_end),
      .bit_end_i(bit_end),
      .bitsel_i(bitsel),
      .p_i, .tri_i,
      .ser_i(ser_i[i]),
      .ser_o(ser_o[i]),
      .ser_oe_o(ser_oe_o[i]),
      .hold_o(hold_all[i]),
      .hold_vld_o(hold_vld[i])
    );
  end

  assign p_o    = hold_all[slot];
  assign p_oe_o = hold_vld[slot];

  p_dir_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(p_oe_o && (|ser_oe_o)));
  p_s2p_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |-> (ser_oe_o == '0));
endmodule

// File: tb/test_tdm_par_ser_conv.sv
module test_tdm_par_ser_conv;
  localparam int CLK_P = 20;
  localparam int FRAME = 2048;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        mode_i = 1'b1, rate_i = 1'b0, fp_i = 1'b0, tri_i = 1'b0;
  logic [7:0]  p_i = '0, p_o;
  logic [31:0] ser_i = '0, ser_o, ser_oe_o;
  logic        p_oe_o;

  int total = 0, bad = 0;
  int bc, g, skip, nstr, chl, bl;
  bit rs_per, done = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  tdm_par_ser_conv i_tdm_par_ser_conv (.*);

  function automatic logic [7:0] dat(int gg, int s);
    return 8'((gg * 53) ^ (s * 29) ^ 165);
  endfunction
  function automatic bit dis(int gg, int s);
    return ((gg * 7 + s * 3) % 5) == 0;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s bc=%0d g=%0d act=%0h exp=%0h", tag, what, bc, g, act, exp);
    end
  endtask

  task automatic start(bit mode, bit rate);
    rst_ni = 1'b0; mode_i = mode; rate_i = rate; fp_i = 0; tri_i = 0; p_i = '0; ser_i = '0;
    repeat (3) @(negedge clk_i);
    chk("R9", "ser_oe in reset", ser_oe_o, 0);
    chk("R9", "p_oe in reset", {31'b0, p_oe_o}, 0);
    rst_ni = 1'b1;
    nstr = rate ? 16 : 32; chl = rate ? 32 : 64; bl = rate ? 4 : 8;
    bc = 0; g = 0; skip = 0; rs_per = 0;
  endtask

  task automatic run(int ncyc, int fp_at);
    for (int n = 0; n < ncyc; n++) begin
      int pos, slot, bidx;
      logic [7:0] b;
      pos = bc % chl; slot = pos / 2; bidx = pos / bl;
      if (mode_i) begin
        chk("R1", "p_oe in p2s", {31'b0, p_oe_o}, 0);
        if (skip == 0) begin
          for (int s = 0; s < 32; s++) begin
            bit eo; string t;
            if (g == 0)          begin eo = 0; t = "R9"; end
            else if (s >= nstr)  begin eo = 0; t = "R3"; end
            else if (dis(g, s))  begin eo = 0; t = "R7"; end
            else                 begin eo = 1; t = "R6"; end
            if (rs_per) t = "R10";
            chk(t, "ser_oe", {31'b0, ser_oe_o[s]}, {31'b0, eo});
            if (eo) begin
              b = dat(g, s);
              if (rs_per)            t = "R10";
              else if (bc == 0)      t = "R2";
              else if (s == nstr-1)  t = "R4";
              else if (bidx == 0)    t = "R5";
              else                   t = "R6";
              chk(t, "ser bit", {31'b0, ser_o[s]}, {31'b0, b[7-bidx]});
            end
          end
        end
        p_i = dat(g + 1, slot); tri_i = dis(g + 1, slot);
        ser_i = $urandom;
      end else begin
        chk("R1", "ser_oe in s2p", ser_oe_o, 0);
        if (skip == 0) begin
          if (g == 0) chk("R9", "p_oe startup", {31'b0, p_oe_o}, 0);
          else begin
            chk(rs_per ? "R10" : "R8", "p_oe", {31'b0, p_oe_o}, 1);
            chk(rs_per ? "R10" : "R8", "p_o", {24'b0, p_o}, {24'b0, dat(g - 1, slot)});
          end
        end
        for (int s = 0; s < 32; s++) begin
          b = dat(g, s);
          ser_i[s] = (s < nstr) ? b[7-bidx] : 1'($urandom);  // R3 upper streams ignored
        end
        p_i = 8'($urandom); tri_i = 1'($urandom);
      end
      fp_i = (n == fp_at) || (bc == FRAME - 1);
      if (fp_i && pos != chl - 1) begin  // mid-period resync
        g++; skip = 1; rs_per = 0;
      end else if (pos == chl - 1) begin
        g++; rs_per = (skip == 1);
        if (skip > 0) skip--;
      end
      bc = fp_i ? 0 : (bc + 1) % FRAME;
      @(negedge clk_i);
    end
  endtask

  initial begin
    @(negedge clk_i);
    start(1'b1, 1'b0); run(4500, -1);
    start(1'b1, 1'b1); run(3000, 1001);
    start(1'b0, 1'b0); run(3000, 1517);
    start(1'b0, 1'b1); run(3000, -1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule